// File: doc/BRIEF.md
# Raster Timing Generator with Event Counters

This block produces the horizontal and vertical timing of a raster display from a set of programmable line and frame totals and edge positions. It runs on the pixel clock. Each clock advances a horizontal position within a line and, at the end of a line, a vertical position within a frame. From these two positions it derives the blanking, sync and active-area levels, three single-cycle event pulses (vertical-blank start, frame start and vertical-sync start) and three counters: a pixel counter, a 24-bit frame counter and a scanline count.

Timing values are written through a small register port into a shadow set. The raster keeps using its working set until the next vertical-blank-start point, where the whole shadow set is copied into the working set at once. Software can therefore reprogram a mode at any time and the change takes effect cleanly at a frame boundary. Most events sit at the horizontal-sync start of a line, not at its first pixel. The frame-start pulse sits at the horizontal-blank start, and a two-bit input can push it back by up to three further lines.

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal position runs 0..htotal-1 and the vertical position 0..vtotal-1. `pix_count` equals line*htotal + position-in-line. It is 0 at the first active pixel of line 0, equals vblank_start*htotal at the first pixel slot of line vblank_start, and returns to 0 after the last pixel slot of the frame.
- R2: `hblank` is high when the position-in-line is at or past the active width. `vblank` is high when the line is at or past vblank_start. `active` is high exactly when both are low.
- R3: `hsync` is high when the position-in-line is at or past hsync_start and below hsync_end.
- R4: `ev_vblank_start` is a one-cycle pulse at position hsync_start of line vblank_start-1 and at no other point of the frame.
- R5: The 24-bit frame count rises by exactly one on the clock edge that ends each `ev_vblank_start` cycle and holds otherwise. `frame_hi` carries bits 23:8 and `frame_lo` bits 7:0, and both update on the same edge.
- R6: `vsync` rises at position hsync_start of line vblank_start+vsync_start_ofs-1 and falls at position hsync_start of line vblank_start+vsync_end_ofs-1. `ev_vsync_start` pulses for one cycle, in the cycle in which `vsync` rises.
- R7: `ev_frame_start` is a one-cycle pulse at position active-width (the start of horizontal blank) on line (vblank_start + `fs_delay`) modulo vtotal, with `fs_delay` in 0..3. The pulse therefore comes 1 to 4 lines after the vertical-blank-start point.
- R8: `scanline` reads line-1, and reads vtotal-1 on line 0. On line vblank_start it therefore reads vblank_start-1.
- R9: A write (`cfg_we` high) at `cfg_addr` stores `cfg_wdata` into a shadow register. The addresses are 0 htotal, 1 active width, 2 hsync_start, 3 hsync_end, 4 vtotal, 5 vblank_start, 6 vsync_start_ofs and 7 vsync_end_ofs. The raster keeps its previous values until the clock edge that ends the next `ev_vblank_start` cycle, when all eight shadow values are copied into the working set.
- R10: During reset (`rst_n` low at a clock edge), both positions, `pix_count` and the frame count are zero, and the shadow and working sets take the parameter defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Shadow register write strobe |
| cfg_addr | input | 3 | Shadow register index |
| cfg_wdata | input | TW (13) | Shadow register write value |
| fs_delay | input | FDW (2) | Extra lines of frame-start delay |
| hsync | output | 1 | Horizontal sync level |
| vsync | output | 1 | Vertical sync level |
| hblank | output | 1 | Horizontal blanking level |
| vblank | output | 1 | Vertical blanking level |
| active | output | 1 | Inside the visible area |
| ev_vblank_start | output | 1 | Vertical-blank-start pulse |
| ev_frame_start | output | 1 | Frame-start pulse |
| ev_vsync_start | output | 1 | Vertical-sync-start pulse |
| pix_count | output | 2*TW (26) | Pixel slots since first active pixel |
| frame_hi | output | FCW-FLW (16) | Frame count upper field |
| frame_lo | output | FLW (8) | Frame count lower field |
| scanline | output | TW (13) | Offset line number |

## Verification
A wrong horizontal or vertical position shows at once in `pix_count`, because that counter no longer steps by one or no longer wraps after htotal*vtotal slots. Within a line it also moves the `hblank`/`hsync` edges away from the positions computed from `pix_count`. A working set that is latched too early or too late changes the line length in the same frame, so it shows as misplaced `hblank` edges at the first line boundary after the write, or after the vertical-blank-start point. A fault in the frame counter or in the event decode shows within one frame, as a pulse at the wrong distance from the vertical-blank-start pulse or as a frame count that differs from the number of pulses seen.

// File: rtl/rtg_pkg.sv
// Shared definitions for the raster timing generator.
// Assumes eight timing registers addressed by a 3-bit index.
package rtg_pkg;

    localparam int NUM_REGS = 8;
    localparam int REG_AW   = $clog2(NUM_REGS);

    // Index of each timing value in the shadow and working sets
    typedef enum logic [REG_AW-1:0] {
        REG_HTOTAL  = 3'd0,
        REG_HACT    = 3'd1,
        REG_HSS     = 3'd2,
        REG_HSE     = 3'd3,
        REG_VTOTAL  = 3'd4,
        REG_VBS     = 3'd5,
        REG_VSO     = 3'd6,
        REG_VEO     = 3'd7
    } reg_idx_e;

endpackage

// File: rtl/rtg_cfg_bank.sv
// Double-buffered timing registers: a shadow set written by the register
// port and a working set that the raster uses. The working set is reloaded
// from the shadow set on any cycle in which 'latch' is high.
// Assumes that the writer and the raster share one clock.
module rtg_cfg_bank #(
    parameter int TW = 13,
    parameter int NR = rtg_pkg::NUM_REGS,
    parameter logic [NR*TW-1:0] INIT = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NR)-1:0]   addr,
    input  logic [TW-1:0]           wdata,
    input  logic                    latch,
    output logic [NR-1:0][TW-1:0]   act
);
    localparam int AW = $clog2(NR);

    logic [NR-1:0][TW-1:0] shadow;
    logic [NR-1:0]         hit;

    // Per-register write select
    genvar g;
    generate
        for (g = 0; g < NR; g++) begin : g_hit
            assign hit[g] = we && (addr == AW'(g));
        end
    endgenerate

    // Shadow set: takes port writes
    always_ff @(posedge clk) begin
        for (int i = 0; i < NR; i++) begin
            if (!rst_n)
                shadow[i] <= INIT[i*TW +: TW];
            else if (hit[i])
                shadow[i] <= wdata;
        end
    end

    // Working set: reloaded as a whole at the latch point
    always_ff @(posedge clk) begin
        for (int i = 0; i < NR; i++) begin
            if (!rst_n)
                act[i] <= INIT[i*TW +: TW];
            else if (latch)
                act[i] <= shadow[i];
        end
    end

endmodule

// File: rtl/rtg_raster.sv
// Horizontal and vertical position counters.
// Assumes htotal and vtotal are at least 2. A position at or past the
// limit also wraps, so a shortened total cannot run the counter away.
module rtg_raster #(
    parameter int TW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] htotal,
    input  logic [TW-1:0] vtotal,
    output logic [TW-1:0] hcnt,
    output logic [TW-1:0] vcnt,
    output logic          frame_end
);
    logic h_last;
    logic v_last;

    assign h_last    = (hcnt >= htotal - TW'(1));
    assign v_last    = (vcnt >= vtotal - TW'(1));
    assign frame_end = h_last && v_last;

    // Position within the line
    always_ff @(posedge clk) begin
        if (!rst_n)
            hcnt <= '0;
        else if (h_last)
            hcnt <= '0;
        else
            hcnt <= hcnt + TW'(1);
    end

    // Line within the frame, stepped at end of line
    always_ff @(posedge clk) begin
        if (!rst_n)
            vcnt <= '0;
        else if (h_last)
            vcnt <= v_last ? '0 : vcnt + TW'(1);
    end

endmodule

// File: rtl/rtg_decode.sv
// Level and event decode from the raster position and the working set.
// Events sit at the horizontal-sync start, except frame start, which sits
// at the horizontal-blank start. Assumes vblank_start >= 1 and vsync lines
// below vtotal.
module rtg_decode #(
    parameter int TW  = 13,
    parameter int FDW = 2
) (
    input  logic [TW-1:0]  hcnt,
    input  logic [TW-1:0]  vcnt,
    input  logic [TW-1:0]  vtotal,
    input  logic [TW-1:0]  hact,
    input  logic [TW-1:0]  hss,
    input  logic [TW-1:0]  hse,
    input  logic [TW-1:0]  vbs,
    input  logic [TW-1:0]  vso,
    input  logic [TW-1:0]  veo,
    input  logic [FDW-1:0] fs_delay,
    output logic           hsync,
    output logic           vsync,
    output logic           hblank,
    output logic           vblank,
    output logic           active,
    output logic           ev_vbs,
    output logic           ev_fs,
    output logic           ev_vs
);
    logic [TW-1:0] sov_line;
    logic [TW-1:0] vs_on_line;
    logic [TW-1:0] vs_off_line;
    logic [TW:0]   fs_sum;
    logic [TW:0]   fs_line;
    logic          at_hss;
    logic          past_on;
    logic          before_off;

    // Line numbers on which the hsync-aligned events fall
    always_comb begin
        sov_line    = vbs - TW'(1);
        vs_on_line  = vbs + vso - TW'(1);
        vs_off_line = vbs + veo - TW'(1);
    end

    // Frame-start line, delayed and folded back into the frame
    always_comb begin
        fs_sum  = {1'b0, vbs} + (TW+1)'(fs_delay);
        fs_line = (fs_sum >= {1'b0, vtotal}) ? fs_sum - {1'b0, vtotal} : fs_sum;
    end

    // Blanking, active and horizontal sync levels
    always_comb begin
        hblank = (hcnt >= hact);
        vblank = (vcnt >= vbs);
        active = !hblank && !vblank;
        hsync  = (hcnt >= hss) && (hcnt < hse);
    end

    // Vertical sync spans from one hsync start to another
    always_comb begin
        at_hss     = (hcnt == hss);
        past_on    = (vcnt > vs_on_line) || ((vcnt == vs_on_line) && (hcnt >= hss));
        before_off = (vcnt < vs_off_line) || ((vcnt == vs_off_line) && (hcnt < hss));
        vsync      = past_on && before_off;
    end

    // Single-position event pulses
    always_comb begin
        ev_vbs = at_hss && (vcnt == sov_line);
        ev_vs  = at_hss && (vcnt == vs_on_line);
        ev_fs  = (hcnt == hact) && ({1'b0, vcnt} == fs_line);
    end

endmodule

// File: rtl/rtg_count.sv
// Pixel, frame and scanline counters.
// The pixel counter restarts with the raster; the frame counter steps on
// each vertical-blank-start event; the scanline reads one line behind.
module rtg_count #(
    parameter int TW  = 13,
    parameter int PXW = 26,
    parameter int FCW = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_end,
    input  logic           ev_vbs,
    input  logic [TW-1:0]  vcnt,
    input  logic [TW-1:0]  vtotal,
    output logic [PXW-1:0] pix,
    output logic [FCW-1:0] frame,
    output logic [TW-1:0]  scanline
);
    // Pixel slots since the first active pixel of the frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            pix <= '0;
        else if (frame_end)
            pix <= '0;
        else
            pix <= pix + PXW'(1);
    end

    // Frame count, stepped at the vertical-blank-start point
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame <= '0;
        else if (ev_vbs)
            frame <= frame + FCW'(1);
    end

    // Offset line number
    always_comb begin
        scanline = (vcnt == '0) ? vtotal - TW'(1) : vcnt - TW'(1);
    end

endmodule

// File: rtl/raster_timing_gen.sv
// Raster timing generator top: register bank, position counters, decode
// and counters. Assumes a single pixel clock domain and legal timing
// values (hact < hss < hse <= htotal, vsync lines inside the frame).
module raster_timing_gen #(
    parameter int TW          = 13,
    parameter int FCW         = 24,
    parameter int FLW         = 8,
    parameter int FDW         = 2,
    parameter int DEF_HTOTAL  = 16,
    parameter int DEF_HACT    = 10,
    parameter int DEF_HSS     = 12,
    parameter int DEF_HSE     = 14,
    parameter int DEF_VTOTAL  = 11,
    parameter int DEF_VBS     = 8,
    parameter int DEF_VSO     = 1,
    parameter int DEF_VEO     = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [rtg_pkg::REG_AW-1:0] cfg_addr,
    input  logic [TW-1:0]             cfg_wdata,
    input  logic [FDW-1:0]            fs_delay,
    output logic                      hsync,
    output logic                      vsync,
    output logic                      hblank,
    output logic                      vblank,
    output logic                      active,
    output logic                      ev_vblank_start,
    output logic                      ev_frame_start,
    output logic                      ev_vsync_start,
    output logic [2*TW-1:0]           pix_count,
    output logic [FCW-FLW-1:0]        frame_hi,
    output logic [FLW-1:0]            frame_lo,
    output logic [TW-1:0]             scanline
);
    import rtg_pkg::*;

    localparam int PXW = 2 * TW;
    localparam logic [NUM_REGS*TW-1:0] INIT = {
        TW'(DEF_VEO), TW'(DEF_VSO), TW'(DEF_VBS), TW'(DEF_VTOTAL),
        TW'(DEF_HSE), TW'(DEF_HSS), TW'(DEF_HACT), TW'(DEF_HTOTAL)
    };

    logic [NUM_REGS-1:0][TW-1:0] cfg;
    logic [TW-1:0]               hcnt;
    logic [TW-1:0]               vcnt;
    logic                        frame_end;
    logic                        sov;
    logic [FCW-1:0]              frame;

    rtg_cfg_bank #(.TW(TW), .NR(NUM_REGS), .INIT(INIT)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .latch (sov),
        .act   (cfg)
    );

    rtg_raster #(.TW(TW)) u_raster (
        .clk       (clk),
        .rst_n     (rst_n),
        .htotal    (cfg[REG_HTOTAL]),
        .vtotal    (cfg[REG_VTOTAL]),
        .hcnt      (hcnt),
        .vcnt      (vcnt),
        .frame_end (frame_end)
    );

    rtg_decode #(.TW(TW), .FDW(FDW)) u_decode (
        .hcnt     (hcnt),
        .vcnt     (vcnt),
        .vtotal   (cfg[REG_VTOTAL]),
        .hact     (cfg[REG_HACT]),
        .hss      (cfg[REG_HSS]),
        .hse      (cfg[REG_HSE]),
        .vbs      (cfg[REG_VBS]),
        .vso      (cfg[REG_VSO]),
        .veo      (cfg[REG_VEO]),
        .fs_delay (fs_delay),
        .hsync    (hsync),
        .vsync    (vsync),
        .hblank   (hblank),
        .vblank   (vblank),
        .active   (active),
        .ev_vbs   (sov),
        .ev_fs    (ev_frame_start),
        .ev_vs    (ev_vsync_start)
    );

    rtg_count #(.TW(TW), .PXW(PXW), .FCW(FCW)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .ev_vbs    (sov),
        .vcnt      (vcnt),
        .vtotal    (cfg[REG_VTOTAL]),
        .pix       (pix_count),
        .frame     (frame),
        .scanline  (scanline)
    );

    // Port mapping of internal results
    assign ev_vblank_start = sov;
    assign frame_hi        = frame[FCW-1:FLW];
    assign frame_lo        = frame[FLW-1:0];

endmodule

// File: rtl/rtg_checker.sv
// Port-level properties of the raster timing generator, bound to the top.
// Assumes the default timing relations (hsync start after active width).
module rtg_checker #(
    parameter int TW  = 13,
    parameter int PXW = 26,
    parameter int FCW = 24,
    parameter int FLW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hsync,
    input logic             vsync,
    input logic             hblank,
    input logic             ev_vblank_start,
    input logic             ev_frame_start,
    input logic             ev_vsync_start,
    input logic [PXW-1:0]   pix_count,
    input logic [FCW-FLW-1:0] frame_hi,
    input logic [FLW-1:0]   frame_lo
);
    logic [FCW-1:0] fc;
    assign fc = {frame_hi, frame_lo};

    // R1: pixel counter steps by one except where it restarts
    a_r1_pix_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_count != '0) |-> (pix_count == $past(pix_count) + PXW'(1)));

    // R4: vertical-blank-start lasts one cycle
    a_r4_sov_single: assert property (@(posedge clk) disable iff (!rst_n)
        ev_vblank_start |=> !ev_vblank_start);

    // R4: vertical-blank-start coincides with hsync start
    a_r4_sov_at_hsync: assert property (@(posedge clk) disable iff (!rst_n)
        ev_vblank_start |-> $rose(hsync));

    // R5: frame count steps by one after the event
    a_r5_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
        ev_vblank_start |=> (fc == $past(fc) + FCW'(1)));

    // R5: frame count holds without the event
    a_r5_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_vblank_start |=> $stable(fc));

    // R6: vsync rises only with its start event
    a_r6_vs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync) |-> ev_vsync_start);

    // R6: the start event comes with vsync high
    a_r6_vs_level: assert property (@(posedge clk) disable iff (!rst_n)
        ev_vsync_start |-> vsync);

    // R7: frame start coincides with horizontal blank start
    a_r7_fs_at_hblank: assert property (@(posedge clk) disable iff (!rst_n)
        ev_frame_start |-> $rose(hblank));

endmodule

bind raster_timing_gen rtg_checker #(.TW(TW), .PXW(PXW), .FCW(FCW), .FLW(FLW)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .hsync           (hsync),
    .vsync           (vsync),
    .hblank          (hblank),
    .ev_vblank_start (ev_vblank_start),
    .ev_frame_start  (ev_frame_start),
    .ev_vsync_start  (ev_vsync_start),
    .pix_count       (pix_count),
    .frame_hi        (frame_hi),
    .frame_lo        (frame_lo)
);

// File: tb/raster_timing_gen_tb_top.sv
// Directed bench for the raster timing generator: one task per scenario.
module raster_timing_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TW  = 13;
    localparam int HT  = 16;
    localparam int HA  = 10;
    localparam int HSS = 12;
    localparam int HSE = 14;
    localparam int VT  = 11;
    localparam int VB  = 8;
    localparam int VSO = 1;
    localparam int VEO = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [TW-1:0] cfg_wdata = '0;
    logic [1:0]    fs_delay = '0;
    logic          hsync, vsync, hblank, vblank, active;
    logic          ev_vblank_start, ev_frame_start, ev_vsync_start;
    logic [25:0]   pix_count;
    logic [15:0]   frame_hi;
    logic [7:0]    frame_lo;
    logic [TW-1:0] scanline;

    int total = 0;
    int bad = 0;
    int nsov = 0;
    bit finished = 0;

    raster_timing_gen #(
        .TW(TW), .DEF_HTOTAL(HT), .DEF_HACT(HA), .DEF_HSS(HSS), .DEF_HSE(HSE),
        .DEF_VTOTAL(VT), .DEF_VBS(VB), .DEF_VSO(VSO), .DEF_VEO(VEO)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .fs_delay(fs_delay), .hsync(hsync), .vsync(vsync),
        .hblank(hblank), .vblank(vblank), .active(active),
        .ev_vblank_start(ev_vblank_start), .ev_frame_start(ev_frame_start),
        .ev_vsync_start(ev_vsync_start), .pix_count(pix_count),
        .frame_hi(frame_hi), .frame_lo(frame_lo), .scanline(scanline)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count vertical-blank-start pulses seen at the ports
    always @(negedge clk) begin
        if (rst_n && ev_vblank_start) nsov <= nsov + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_frame();
        do @(negedge clk); while (pix_count != 0);
    endtask

    task automatic wait_sov();
        do @(negedge clk); while (!ev_vblank_start);
    endtask

    task automatic wr(input int a, input int d);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = TW'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R10: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(pix_count == 0, "R10", "pix_count in reset", pix_count, 0);
        check({frame_hi, frame_lo} == 0, "R10", "frame in reset", {frame_hi, frame_lo}, 0);
        check(scanline == VT-1, "R10", "scanline in reset (line 0)", scanline, VT-1);
        check(active && !ev_vblank_start && !ev_frame_start && !ev_vsync_start,
              "R10", "active and no events in reset", {active, ev_vblank_start}, 2);
        rst_n = 1'b1;
    endtask

    // R1 R2 R3 R4 R6 R7 R8: one full frame compared against position
    task automatic t_levels();
        int e1 = 0, e2 = 0, e3 = 0, e4 = 0, e6 = 0, e7 = 0, e8 = 0;
        int vs_on  = (VB+VSO-1)*HT + HSS;
        int vs_off = (VB+VEO-1)*HT + HSS;
        wait_frame();
        for (int i = 0; i < HT*VT; i++) begin
            int h = i % HT;
            int v = i / HT;
            if (pix_count != 26'(i)) e1++;
            if (hblank != (h >= HA) || vblank != (v >= VB) ||
                active != (h < HA && v < VB)) e2++;
            if (hsync != (h >= HSS && h < HSE)) e3++;
            if (ev_vblank_start != (i == (VB-1)*HT + HSS)) e4++;
            if (vsync != (i >= vs_on && i < vs_off) || ev_vsync_start != (i == vs_on)) e6++;
            if (ev_frame_start != (i == VB*HT + HA)) e7++;
            if (scanline != TW'((v == 0) ? VT-1 : v-1)) e8++;
            @(negedge clk);
        end
        check(e1 == 0 && pix_count == 0, "R1", "pixel sequence/wrap mismatches", e1, 0);
        check(e2 == 0, "R2", "blank/active mismatches", e2, 0);
        check(e3 == 0, "R3", "hsync mismatches", e3, 0);
        check(e4 == 0, "R4", "vblank-start event mismatches", e4, 0);
        check(e6 == 0, "R6", "vsync mismatches", e6, 0);
        check(e7 == 0, "R7", "frame-start mismatches", e7, 0);
        check(e8 == 0, "R8", "scanline mismatches", e8, 0);
    endtask

    // R4 R5 R1 R8: vblank-start point and what follows
    task automatic t_sov();
        longint f0;
        wait_sov();
        check(pix_count == (VB-1)*HT + HSS, "R4", "pix at vblank start", pix_count, (VB-1)*HT + HSS);
        check(scanline == VB-2, "R8", "scanline at vblank start", scanline, VB-2);
        f0 = {frame_hi, frame_lo};
        @(negedge clk);
        check(!ev_vblank_start, "R4", "event one cycle", ev_vblank_start, 0);
        check({frame_hi, frame_lo} == f0 + 1, "R5", "frame step", {frame_hi, frame_lo}, f0 + 1);
        repeat (3) @(negedge clk);
        check(pix_count == VB*HT, "R1", "pix at first slot of vblank line", pix_count, VB*HT);
        check(scanline == VB-1 && vblank, "R8", "scanline on vblank line", scanline, VB-1);
    endtask

    // R6: vsync timing relative to vblank start
    task automatic t_vsync();
        int n = 0, m = 0;
        wait_sov();
        while (!ev_vsync_start) begin @(negedge clk); n++; end
        check(n == VSO*HT, "R6", "cycles vblank-start to vsync-start", n, VSO*HT);
        check(vsync, "R6", "vsync high at its event", vsync, 1);
        while (vsync) begin @(negedge clk); m++; end
        check(m == (VEO-VSO)*HT, "R6", "vsync width", m, (VEO-VSO)*HT);
    endtask

    // R7: frame start with delay d
    task automatic t_fs(input int d);
        int n = 0;
        wait_frame();
        fs_delay = 2'(d);
        wait_sov();
        while (!ev_frame_start) begin @(negedge clk); n++; end
        check(n == HT*(1+d) + HA - HSS, "R7", $sformatf("frame-start distance delay %0d", d),
              n, HT*(1+d) + HA - HSS);
        @(negedge clk);
        check(!ev_frame_start, "R7", "frame start one cycle", ev_frame_start, 0);
        fs_delay = '0;
    endtask

    // R9: shadow write takes effect only at the next vblank start
    task automatic t_shadow();
        int n = 0;
        wait_frame();
        do @(negedge clk); while (!ev_frame_start);
        wr(0, 20);
        wait_frame();
        repeat (16) @(negedge clk);
        check(!hblank, "R9", "old line length kept before latch", hblank, 0);
        wait_sov();
        repeat (4) @(negedge clk);
        check(hblank && scanline == VB-2, "R9", "new line length after latch", hblank, 1);
        wait_frame();
        do begin @(negedge clk); n++; end while (pix_count != 0);
        check(n == 20*VT, "R9", "frame length with new htotal", n, 20*VT);
        wr(0, HT);
        wait_frame();
    endtask

    // R5: frame count crosses the low/high field boundary
    task automatic t_split();
        wait_frame();
        check({frame_hi, frame_lo} == nsov, "R5", "frame equals pulses seen", {frame_hi, frame_lo}, nsov);
        while (nsov < 257) wait_frame();
        check(frame_hi == 16'(nsov >> 8) && frame_hi >= 1, "R5", "frame_hi after carry", frame_hi, nsov >> 8);
        check(frame_lo == 8'(nsov), "R5", "frame_lo after carry", frame_lo, nsov & 255);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_levels();
        t_sov();
        t_vsync();
        for (int d = 0; d < 4; d++) t_fs(d);
        t_shadow();
        t_levels();
        t_split();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule